// File: doc/BRIEF.md
# Built-In Self-Test Sequencer with Channel Fault Isolation

This controller runs a self-test of a unit when it receives a start pulse. It first checks supply health. It then tests two signal channels, P and G, always in that order. While a channel is under test, its stimulus relay is energized. A comparator reports whether the expected response arrived. When a channel fails, the sequencer narrows the fault to a single buffer stage. It selects each of the four stages that belong to that channel in turn, with a one-hot select, and keeps a per-stage result. Channel P owns the odd-numbered stages (1, 3, 5, 7) and channel G owns the even-numbered stages (2, 4, 6, 8). Stage n is bit n-1 of every 8-bit stage vector.

Each test step lasts a fixed number of ticks of a parameterized divider. The comparator is sampled only at the end of the step, once the relays and the select have had time to settle. A failed supply check ends the run at once and lights only the unit-fail lamp. Otherwise the sequencer reports the outcome on a GO lamp and on two channel lamps. Both channel lamps may be lit together. Lamps and stage results hold until the next run completes or until a synchronous clear.

Top module: `bist_sequencer`

## Requirements
- R1: A start pulse is accepted only while idle. Busy is high from the cycle after an accepted start until the run completes. A start pulse that arrives while busy has no effect on the run or on its length.
- R2: The steps always run in this order: a supply step with no relay energized, then a channel P step with only relay_p_o high, then a channel G step with only relay_g_o high. The two relays are never high together. Both relays and the stage select are low while idle.
- R3: Every step, including each isolation stage, lasts exactly SETTLE_TICKS*TICK_DIV clock cycles. The check input is sampled in the last cycle of the step. A run in which everything passes is therefore busy for 3*SETTLE_TICKS*TICK_DIV cycles, and each isolated stage adds one further step.
- R4: If pwr_ok_i is low at the end of the supply step, the run ends after that step with no relay ever energized. Only the unit lamp is lit, and the stage results are zero.
- R5: If channel P fails, relay_p_o stays high and stage_sel_o selects bits 0, 2, 4, 6 one at a time in that order, before the G step begins.
- R6: If channel G fails, relay_g_o stays high and stage_sel_o selects bits 1, 3, 5, 7 one at a time in that order.
- R7: Bit k of stage_fail_o is 1 when step_pass_i was low at the end of the step that selected bit k. Bits of stages that were not isolated read 0. The vector updates only when a run completes.
- R8: The lamps follow these rules:
  - lamp_go_o lights only when the supply and both channels pass.
  - lamp_p_o lights when channel P failed, and lamp_g_o lights when channel G failed. Both may be lit together.
  - lamp_unit_o excludes every other lamp.
- R9: The lamps and stage results hold their values from one completion until the next completion or clear. A new run keeps showing the old values while busy and replaces them when it completes.
- R10: clear_i, sampled on a clock edge, blanks all lamps and stage results. It also returns a running sequence to idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of results; aborts a run |
| start_i | input | 1 | Start pulse |
| pwr_ok_i | input | 1 | Supply-healthy comparator flag, 1 = healthy |
| step_pass_i | input | 1 | Pass flag of the current step, 1 = pass |
| busy_o | output | 1 | Sequence running |
| relay_p_o | output | 1 | Stimulus relay enable, channel P |
| relay_g_o | output | 1 | Stimulus relay enable, channel G |
| stage_sel_o | output | 8 | One-hot buffer stage select, bit n-1 = stage n |
| lamp_go_o | output | 1 | All tests passed |
| lamp_unit_o | output | 1 | Unit (supply) fault |
| lamp_p_o | output | 1 | Channel P fault |
| lamp_g_o | output | 1 | Channel G fault |
| stage_fail_o | output | 8 | Stored per-stage failures, bit n-1 = stage n |

## Verification
The bench models the plant. It answers the relay and stage-select outputs with pass or fail flags taken from a per-run fault pattern. Because the plant reacts to those outputs, the sequencer's step order shows up in the responses it receives.

The patterns cover these cases:
- A clean unit.
- A supply fault that is masked together with channel faults, which shows the abort and its precedence.
- Each channel failing alone, with a fault on some of its stages, on none of them, or only on the other channel's stages. This separates the odd and even stage sets and rules out isolation of the channel that passed.
- Both channels failing, which shows the dual lamps and the worst-case run length.

Directed runs then try a start pulse during a run, a rerun over stale results, and a clear, both mid-run and while idle.

// File: rtl/bist_pkg.sv
package bist_pkg;
    localparam int unsigned STAGES = 8;
    localparam int unsigned PER_CH = STAGES / 2;
    localparam int unsigned IDX_W  = (PER_CH > 1) ? $clog2(PER_CH) : 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWR,
        ST_CHP,
        ST_ISOP,
        ST_CHG,
        ST_ISOG
    } step_e;

    typedef struct packed {
        logic go;
        logic unit;
        logic chp;
        logic chg;
    } lamps_t;
endpackage

// File: rtl/bist_tick_gen.sv
module bist_tick_gen #(
    parameter int unsigned TICK_DIV = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int unsigned DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

    typedef struct packed {
        logic [DW-1:0] cnt;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (restart_i || div_q.cnt == LAST) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign tick_o = (div_q.cnt == LAST);
endmodule

// File: rtl/bist_step_ctrl.sv
module bist_step_ctrl
    import bist_pkg::*;
#(
    parameter int unsigned SETTLE_TICKS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              start_i,
    input  logic              pwr_ok_i,
    input  logic              step_pass_i,
    input  logic              tick_i,
    output logic              restart_o,
    output logic              busy_o,
    output logic              relay_p_o,
    output logic              relay_g_o,
    output logic [STAGES-1:0] stage_sel_o,
    output logic              done_o,
    output lamps_t            done_lamps_o,
    output logic [STAGES-1:0] done_res_o
);
    localparam int unsigned TW = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;
    localparam logic [TW-1:0]    T_LAST = TW'(SETTLE_TICKS - 1);
    localparam logic [IDX_W-1:0] I_LAST = IDX_W'(PER_CH - 1);

    typedef struct packed {
        step_e             step;
        logic [IDX_W-1:0]  idx;
        logic [TW-1:0]     tcnt;
        logic              p_bad;
        logic              g_bad;
        logic [STAGES-1:0] res;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  sample;
    logic  finish;

    assign sample = tick_i && (ctrl_q.tcnt == T_LAST);

    always_comb begin
        ctrl_d       = ctrl_q;
        restart_o    = 1'b0;
        done_o       = 1'b0;
        done_lamps_o = '0;
        finish       = 1'b0;

        if (ctrl_q.step != ST_IDLE && tick_i && !sample) begin
            ctrl_d.tcnt = ctrl_q.tcnt + 1'b1;
        end

        unique case (ctrl_q.step)
            ST_IDLE: begin
                if (start_i) begin
                    ctrl_d.step  = ST_PWR;
                    ctrl_d.tcnt  = '0;
                    ctrl_d.idx   = '0;
                    ctrl_d.p_bad = 1'b0;
                    ctrl_d.g_bad = 1'b0;
                    ctrl_d.res   = '0;
                    restart_o    = 1'b1;
                end
            end
            ST_PWR: begin
                if (sample) begin
                    if (!pwr_ok_i) begin
                        ctrl_d.step       = ST_IDLE;
                        done_o            = 1'b1;
                        done_lamps_o.unit = 1'b1;
                    end else begin
                        ctrl_d.step = ST_CHP;
                    end
                end
            end
            ST_CHP: begin
                if (sample) begin
                    if (!step_pass_i) begin
                        ctrl_d.p_bad = 1'b1;
                        ctrl_d.idx   = '0;
                        ctrl_d.step  = ST_ISOP;
                    end else begin
                        ctrl_d.step = ST_CHG;
                    end
                end
            end
            ST_ISOP: begin
                if (sample) begin
                    ctrl_d.res[int'(ctrl_q.idx) * 2] = !step_pass_i;
                    if (ctrl_q.idx == I_LAST) begin
                        ctrl_d.step = ST_CHG;
                    end else begin
                        ctrl_d.idx = ctrl_q.idx + 1'b1;
                    end
                end
            end
            ST_CHG: begin
                if (sample) begin
                    if (!step_pass_i) begin
                        ctrl_d.g_bad = 1'b1;
                        ctrl_d.idx   = '0;
                        ctrl_d.step  = ST_ISOG;
                    end else begin
                        finish = 1'b1;
                    end
                end
            end
            ST_ISOG: begin
                if (sample) begin
                    ctrl_d.res[int'(ctrl_q.idx) * 2 + 1] = !step_pass_i;
                    if (ctrl_q.idx == I_LAST) begin
                        finish = 1'b1;
                    end else begin
                        ctrl_d.idx = ctrl_q.idx + 1'b1;
                    end
                end
            end
            default: ctrl_d.step = ST_IDLE;
        endcase

        if (ctrl_q.step != ST_IDLE && sample) begin
            ctrl_d.tcnt = '0;
            restart_o   = 1'b1;
        end

        if (finish) begin
            ctrl_d.step      = ST_IDLE;
            done_o           = 1'b1;
            done_lamps_o.go  = !ctrl_d.p_bad && !ctrl_d.g_bad;
            done_lamps_o.chp = ctrl_d.p_bad;
            done_lamps_o.chg = ctrl_d.g_bad;
        end

        if (clear_i) begin
            ctrl_d       = '0;
            ctrl_d.step  = ST_IDLE;
            restart_o    = 1'b0;
            done_o       = 1'b0;
            done_lamps_o = '0;
        end
    end

    assign done_res_o = done_lamps_o.unit ? '0 : ctrl_d.res;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            ctrl_q.step <= ST_IDLE;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy_o    = (ctrl_q.step != ST_IDLE);
    assign relay_p_o = (ctrl_q.step == ST_CHP) || (ctrl_q.step == ST_ISOP);
    assign relay_g_o = (ctrl_q.step == ST_CHG) || (ctrl_q.step == ST_ISOG);

    for (genvar k = 0; k < STAGES; k++) begin : g_sel
        if (k % 2 == 0) begin : g_p
            assign stage_sel_o[k] = (ctrl_q.step == ST_ISOP) && (ctrl_q.idx == IDX_W'(k / 2));
        end else begin : g_g
            assign stage_sel_o[k] = (ctrl_q.step == ST_ISOG) && (ctrl_q.idx == IDX_W'(k / 2));
        end
    end

    p_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && !clear_i && !done_o |=> busy_o);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !relay_p_o && !relay_g_o && stage_sel_o == '0);

    p_pwr_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.step == ST_PWR && sample && !pwr_ok_i && !clear_i |=> !busy_o && !relay_p_o);

    p_iso_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.step == ST_CHP && sample && !step_pass_i && !clear_i |=> stage_sel_o[0] && relay_p_o);

    p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stage_sel_o));

    p_clear_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !busy_o);
endmodule

// File: rtl/bist_lamp_hold.sv
module bist_lamp_hold
    import bist_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              done_i,
    input  lamps_t            lamps_i,
    input  logic [STAGES-1:0] res_i,
    output lamps_t            lamps_o,
    output logic [STAGES-1:0] res_o
);
    typedef struct packed {
        lamps_t            lamps;
        logic [STAGES-1:0] res;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (clear_i) begin
            hold_d = '0;
        end else if (done_i) begin
            hold_d.lamps = lamps_i;
            hold_d.res   = res_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign lamps_o = hold_q.lamps;
    assign res_o   = hold_q.res;

    p_unit_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lamps_o.unit |-> !lamps_o.go && !lamps_o.chp && !lamps_o.chg && res_o == '0);

    p_go_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lamps_o.go |-> !lamps_o.chp && !lamps_o.chg && res_o == '0);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i && !clear_i |=> $stable(lamps_o) && $stable(res_o));

    p_clear_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> lamps_o == '0 && res_o == '0);
endmodule

// File: rtl/bist_sequencer.sv
module bist_sequencer
    import bist_pkg::*;
#(
    parameter int unsigned TICK_DIV     = 500000,
    parameter int unsigned SETTLE_TICKS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              start_i,
    input  logic              pwr_ok_i,
    input  logic              step_pass_i,
    output logic              busy_o,
    output logic              relay_p_o,
    output logic              relay_g_o,
    output logic [STAGES-1:0] stage_sel_o,
    output logic              lamp_go_o,
    output logic              lamp_unit_o,
    output logic              lamp_p_o,
    output logic              lamp_g_o,
    output logic [STAGES-1:0] stage_fail_o
);
    logic              tick;
    logic              restart;
    logic              done;
    lamps_t            done_lamps;
    logic [STAGES-1:0] done_res;
    lamps_t            lamps;

    bist_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .tick_o    (tick)
    );

    bist_step_ctrl #(.SETTLE_TICKS(SETTLE_TICKS)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear_i),
        .start_i      (start_i),
        .pwr_ok_i     (pwr_ok_i),
        .step_pass_i  (step_pass_i),
        .tick_i       (tick),
        .restart_o    (restart),
        .busy_o       (busy_o),
        .relay_p_o    (relay_p_o),
        .relay_g_o    (relay_g_o),
        .stage_sel_o  (stage_sel_o),
        .done_o       (done),
        .done_lamps_o (done_lamps),
        .done_res_o   (done_res)
    );

    bist_lamp_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .done_i  (done),
        .lamps_i (done_lamps),
        .res_i   (done_res),
        .lamps_o (lamps),
        .res_o   (stage_fail_o)
    );

    assign lamp_go_o   = lamps.go;
    assign lamp_unit_o = lamps.unit;
    assign lamp_p_o    = lamps.chp;
    assign lamp_g_o    = lamps.chg;

    p_relay_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(relay_p_o && relay_g_o));
endmodule

// File: tb/bist_sequencer_tb.sv
module bist_sequencer_tb_top;
    localparam int unsigned TD   = 4;
    localparam int unsigned ST   = 2;
    localparam int unsigned STEP = TD * ST;

    typedef struct packed {
        logic       pbad;
        logic       pf;
        logic       gf;
        logic [7:0] sf;
        logic [3:0] lamps;
        logic [7:0] res;
    } vec_t;

    // lamps field: {go, unit, p, g}
    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        {1'b0, 1'b0, 1'b0, 8'h00, 4'b1000, 8'h00},
        {1'b1, 1'b1, 1'b1, 8'hFF, 4'b0100, 8'h00},
        {1'b0, 1'b1, 1'b0, 8'h44, 4'b0010, 8'h44},
        {1'b0, 1'b0, 1'b1, 8'h82, 4'b0001, 8'h82},
        {1'b0, 1'b1, 1'b1, 8'hFF, 4'b0011, 8'hFF},
        {1'b0, 1'b1, 1'b0, 8'h00, 4'b0010, 8'h00},
        {1'b0, 1'b0, 1'b0, 8'hFF, 4'b1000, 8'h00},
        {1'b0, 1'b1, 1'b1, 8'h5A, 4'b0011, 8'h5A},
        {1'b0, 1'b0, 1'b1, 8'h55, 4'b0001, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear_i = 1'b0;
    logic       start_i = 1'b0;
    logic       pwr_ok_i;
    logic       step_pass_i;
    logic       busy_o, relay_p_o, relay_g_o;
    logic [7:0] stage_sel_o, stage_fail_o;
    logic       lamp_go_o, lamp_unit_o, lamp_p_o, lamp_g_o;

    logic       m_pbad = 1'b0, m_pf = 1'b0, m_gf = 1'b0;
    logic [7:0] m_sf = 8'h00;

    int checks = 0;
    int fails  = 0;

    always #10ns clk = ~clk;

    bist_sequencer #(.TICK_DIV(TD), .SETTLE_TICKS(ST)) dut_i (
        .clk, .rst_n, .clear_i, .start_i, .pwr_ok_i, .step_pass_i,
        .busy_o, .relay_p_o, .relay_g_o, .stage_sel_o,
        .lamp_go_o, .lamp_unit_o, .lamp_p_o, .lamp_g_o, .stage_fail_o
    );

    // plant model: responds to relay and select outputs
    always_comb begin
        pwr_ok_i = !m_pbad;
        if (stage_sel_o != 8'h00)  step_pass_i = !(|(stage_sel_o & m_sf));
        else if (relay_p_o)        step_pass_i = !m_pf;
        else if (relay_g_o)        step_pass_i = !m_gf;
        else                       step_pass_i = 1'b1;
    end

    function automatic logic [3:0] lamps_now();
        return {lamp_go_o, lamp_unit_o, lamp_p_o, lamp_g_o};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic pbad, input logic pf, input logic gf, input logic [7:0] sf,
                       input int start_at, input int clear_at, input int probe_at,
                       output int cyc, output logic [31:0] seq, output int nsel,
                       output int order_err, output int pcyc, output logic [3:0] probe);
        logic [7:0] prev;
        logic seen_g;
        m_pbad = pbad; m_pf = pf; m_gf = gf; m_sf = sf;
        cyc = 0; seq = 0; nsel = 0; order_err = 0; pcyc = 0; probe = 4'h0;
        prev = 8'h00; seen_g = 1'b0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        while (busy_o && cyc < 4000) begin
            cyc++;
            if (relay_p_o) pcyc++;
            if (relay_p_o && relay_g_o) order_err++;
            if (relay_g_o) seen_g = 1'b1;
            if (relay_p_o && seen_g) order_err++;
            if (pbad && (relay_p_o || relay_g_o)) order_err++;
            if (stage_sel_o != 8'h00 && stage_sel_o != prev) begin
                for (int b = 0; b < 8; b++)
                    if (stage_sel_o[b]) seq = (seq << 4) | 32'(b + 1);
                nsel++;
            end
            prev = stage_sel_o;
            if (cyc == probe_at) probe = lamps_now();
            start_i = (cyc == start_at);
            clear_i = (cyc == clear_at);
            @(negedge clk);
        end
        start_i = 1'b0;
        clear_i = 1'b0;
    endtask

    initial begin
        #4ms;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int cyc, nsel, oerr, pcyc, en;
        logic [31:0] seq, es;
        logic [3:0] probe;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R2, R10)
        chk("R2", "busy/relays/select after reset", {busy_o, relay_p_o, relay_g_o, stage_sel_o}, 0);
        chk("R10", "lamps/results after reset", {lamps_now(), stage_fail_o}, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            t = VECS[v];
            run(t.pbad, t.pf, t.gf, t.sf, -1, -1, -1, cyc, seq, nsel, oerr, pcyc, probe);
            es = 0; en = 0;
            if (!t.pbad) begin
                if (t.pf) for (int k = 0; k < 4; k++) begin es = (es << 4) | 32'(2 * k + 1); en++; end
                if (t.gf) for (int k = 0; k < 4; k++) begin es = (es << 4) | 32'(2 * k + 2); en++; end
            end
            chk("R8", $sformatf("lamps vec %0d", v), 32'(lamps_now()), 32'(t.lamps));
            chk("R7", $sformatf("stage results vec %0d", v), 32'(stage_fail_o), 32'(t.res));
            chk("R3", $sformatf("busy cycles vec %0d", v), cyc,
                t.pbad ? STEP : STEP * (3 + 4 * int'(t.pf) + 4 * int'(t.gf)));
            chk(t.gf && !t.pf ? "R6" : "R5", $sformatf("stage order vec %0d", v), seq, es);
            chk("R5", $sformatf("stage count vec %0d", v), nsel, en);
            chk(t.pbad ? "R4" : "R2", $sformatf("relay order vec %0d", v), oerr, 0);
            if (!t.pbad && !t.pf)
                chk("R3", $sformatf("P relay length vec %0d", v), pcyc, STEP);
        end

        // R1: start while busy is ignored
        run(0, 0, 0, 8'h00, 5, -1, -1, cyc, seq, nsel, oerr, pcyc, probe);
        chk("R1", "run length with start while busy", cyc, 3 * STEP);
        repeat (5) @(negedge clk);
        chk("R1", "idle after ignored start", busy_o, 0);

        // R9: results hold during rerun, replaced at completion
        run(0, 1, 1, 8'h0F, -1, -1, -1, cyc, seq, nsel, oerr, pcyc, probe);
        repeat (7) @(negedge clk);
        chk("R9", "hold while idle", {lamps_now(), stage_fail_o}, {4'b0011, 8'h0F});
        run(0, 0, 0, 8'h00, -1, -1, 10, cyc, seq, nsel, oerr, pcyc, probe);
        chk("R9", "old lamps during rerun", probe, 4'b0011);
        chk("R9", "replaced after rerun", {lamps_now(), stage_fail_o}, {4'b1000, 8'h00});

        // R10: clear mid-run aborts and blanks
        run(0, 1, 0, 8'h01, -1, 12, -1, cyc, seq, nsel, oerr, pcyc, probe);
        chk("R10", "abort cycle on clear", cyc, 12);
        chk("R10", "blank after mid-run clear", {busy_o, lamps_now(), stage_fail_o}, 0);

        // R10: clear while idle blanks
        run(0, 1, 0, 8'h04, -1, -1, -1, cyc, seq, nsel, oerr, pcyc, probe);
        chk("R7", "results before idle clear", stage_fail_o, 8'h04);
        @(negedge clk) clear_i = 1'b1;
        @(negedge clk) clear_i = 1'b0;
        chk("R10", "blank after idle clear", {lamps_now(), stage_fail_o}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule